// File: doc/BRIEF.md
# Recovered-Clock Frequency Error Detector

This block decides whether a recovered line clock runs at the right rate. It takes the fast recovered clock and a local reference clock. The reference runs at one eighth of the line rate, for example 19.44 MHz against a 155.52 Mbit/s stream. The same ratio holds for a 311.04 MBaud coded stream, because that stream is recovered at the same bit clock.

Counting works as follows:
- The fast clock is divided by eight.
- The divided ticks are counted over a gate window. The window is a fixed number of reference cycles.
- At the end of each window, the tick count is handed to the reference domain by a toggle handshake. No multi-bit value is ever sampled while it can change.
- The count is then compared with the window length.

The error flag uses two thresholds, so it has hysteresis:
- A gap larger than 3 parts in 200 raises the flag.
- A gap smaller than 1 part in 200 lowers it.
- A gap between the two leaves the flag unchanged.

The flag starts high after reset. A loop controller uses it to choose between tracking the data and steering towards the reference.

Top module: `freq_err_det`

## Requirements
- R1: `freq_err_o` is 1 while `rst_ni` is low. It stays 1 after reset until the first complete gate window yields a count inside the clear threshold.
- R2: The block counts one tick per 8 cycles of `rec_clk_i`, over a gate of `GATE_LEN` cycles of `ref_clk_i`. A recovered clock at exactly 8 times the reference therefore gives a count of `GATE_LEN` and drives the flag to 0.
- R3: If |count − `GATE_LEN`| > `GATE_LEN`·3/200, the flag becomes 1. This holds for a recovered clock that is too fast and for one that is too slow.
- R4: If |count − `GATE_LEN`| < `GATE_LEN`/200, the flag becomes 0.
- R5: If the gap is at least the clear threshold and at most the set threshold, the flag keeps its previous value, whether that value is 0 or 1.
- R6: The flag changes only in the cycle after a window's verdict is formed. Two changes are never less than `GATE_LEN` reference cycles apart.
- R7: The count held for transfer stays stable between window closes. It reaches the reference domain only through a toggle handshake, so the result is correct for any phase relation between the two clocks.
- R8: The tick counter is $clog2(`GATE_LEN`)+2 bits wide and saturates at its all-ones value. A grossly fast clock therefore sets the flag and never wraps to a count that looks good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Local reference clock, nominally line rate / 8 |
| rec_clk_i | input | 1 | Recovered line-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| freq_err_o | output | 1 | Frequency error flag, registered in the reference domain |

## Verification
In the recovered-clock domain, the close of a window and a divide-by-eight tick can fall in the same cycle. That tick must be credited to the window that is closing, not lost and not counted twice. The bench provokes this by starting the recovered clock at a random phase and by changing its period many times, which moves the tick phase against the synchronized gate edge. The result is judged by counts that stay within one of the window length at the nominal rate, so the flag stays low, and by the hold-band expectations, which would break if a tick were dropped or doubled.

// File: rtl/fed_pkg.sv
package fed_pkg;

  typedef enum logic [1:0] {
    VERD_HOLD = 2'd0,
    VERD_SET  = 2'd1,
    VERD_CLR  = 2'd2
  } verdict_e;

  function automatic int unsigned abs_gap(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/fed_sync.sv
module fed_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/fed_gate_gen.sv
module fed_gate_gen #(
  parameter int unsigned GATE_LEN = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic gate_tgl_o
);

  localparam int unsigned GW = $clog2(GATE_LEN);

  logic [GW-1:0] gcnt_q;
  logic          last;

  assign last = (gcnt_q == GW'(GATE_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gcnt_q     <= '0;
      gate_tgl_o <= 1'b0;
    end else begin
      gcnt_q <= last ? '0 : gcnt_q + 1'b1;
      if (last) gate_tgl_o <= ~gate_tgl_o;
    end
  end

endmodule

// File: rtl/fed_rec_cnt.sv
module fed_rec_cnt #(
  parameter int unsigned DIV       = 8,
  parameter int unsigned CNT_W     = 13,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_tgl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hold_o,
  output logic             gate_edge_o,
  output logic             ack_tgl_o
);

  localparam int unsigned PRE_W = $clog2(DIV);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0] pre_q;
  logic             tick;
  logic             gate_s, gate_d_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, hold_q;
  logic             ack_q;

  fed_sync #(.STAGES(SYNC_STGS), .WIDTH(1)) u_gate_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gate_tgl_i),
    .q_o    (gate_s)
  );

  assign tick        = (pre_q == PRE_W'(DIV - 1));
  assign gate_edge_o = gate_s ^ gate_d_q;
  // a tick landing on the close cycle belongs to the closing window
  assign cnt_nxt     = (tick && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= '0;
      gate_d_q <= 1'b0;
      cnt_q    <= '0;
      hold_q   <= '0;
      ack_q    <= 1'b0;
    end else begin
      pre_q    <= tick ? '0 : pre_q + 1'b1;
      gate_d_q <= gate_s;
      if (gate_edge_o) begin
        hold_q <= cnt_nxt;
        cnt_q  <= '0;
        ack_q  <= ~ack_q;
      end else begin
        cnt_q  <= cnt_nxt;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign hold_o    = hold_q;
  assign ack_tgl_o = ack_q;

endmodule

// File: rtl/fed_judge.sv
module fed_judge
  import fed_pkg::*;
#(
  parameter int unsigned GATE_LEN  = 1600,
  parameter int unsigned CNT_W     = 13,
  parameter int unsigned SET_THR   = 24,
  parameter int unsigned CLR_THR   = 8,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_tgl_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             cap_vld_o,
  output logic             verd_vld_o,
  output logic             flag_o
);

  logic             ack_s, ack_d_q, new_cnt;
  logic [CNT_W-1:0] cap_q;
  logic             cap_vld_q, verd_vld_q, flag_q;
  int unsigned      gap;
  verdict_e         verd, verd_q;

  fed_sync #(.STAGES(SYNC_STGS), .WIDTH(1)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ack_tgl_i),
    .q_o    (ack_s)
  );

  assign new_cnt = ack_s ^ ack_d_q;

  always_comb begin
    gap = abs_gap(32'(cap_q), GATE_LEN);
    if (gap > SET_THR)      verd = VERD_SET;
    else if (gap < CLR_THR) verd = VERD_CLR;
    else                    verd = VERD_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_d_q    <= 1'b0;
      cap_q      <= '0;
      cap_vld_q  <= 1'b0;
      verd_q     <= VERD_HOLD;
      verd_vld_q <= 1'b0;
      flag_q     <= 1'b1;
    end else begin
      ack_d_q    <= ack_s;
      cap_vld_q  <= new_cnt;
      if (new_cnt) cap_q <= hold_i;
      verd_vld_q <= cap_vld_q;
      if (cap_vld_q) verd_q <= verd;
      if (verd_vld_q) begin
        unique case (verd_q)
          VERD_SET:  flag_q <= 1'b1;
          VERD_CLR:  flag_q <= 1'b0;
          default:   flag_q <= flag_q;
        endcase
      end
    end
  end

  assign cap_o      = cap_q;
  assign cap_vld_o  = cap_vld_q;
  assign verd_vld_o = verd_vld_q;
  assign flag_o     = flag_q;

endmodule

// File: rtl/freq_err_det.sv
module freq_err_det #(
  parameter int unsigned GATE_LEN  = 1600,
  parameter int unsigned DIV       = 8,
  parameter int unsigned SET_NUM   = 3,
  parameter int unsigned CLR_NUM   = 1,
  parameter int unsigned RATIO_DEN = 200,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic ref_clk_i,
  input  logic rec_clk_i,
  input  logic rst_ni,
  output logic freq_err_o
);

  localparam int unsigned CNT_W   = $clog2(GATE_LEN) + 2;
  localparam int unsigned SET_THR = GATE_LEN * SET_NUM / RATIO_DEN;
  localparam int unsigned CLR_THR = GATE_LEN * CLR_NUM / RATIO_DEN;

  logic             gate_tgl, ack_tgl, gate_edge_rec;
  logic [CNT_W-1:0] rec_cnt, hold_cnt, cap_cnt;
  logic             cap_vld, verd_vld;

  fed_gate_gen #(.GATE_LEN(GATE_LEN)) u_gate (
    .clk_i      (ref_clk_i),
    .rst_ni     (rst_ni),
    .gate_tgl_o (gate_tgl)
  );

  fed_rec_cnt #(.DIV(DIV), .CNT_W(CNT_W), .SYNC_STGS(SYNC_STGS)) u_rec (
    .clk_i       (rec_clk_i),
    .rst_ni      (rst_ni),
    .gate_tgl_i  (gate_tgl),
    .cnt_o       (rec_cnt),
    .hold_o      (hold_cnt),
    .gate_edge_o (gate_edge_rec),
    .ack_tgl_o   (ack_tgl)
  );

  fed_judge #(
    .GATE_LEN  (GATE_LEN),
    .CNT_W     (CNT_W),
    .SET_THR   (SET_THR),
    .CLR_THR   (CLR_THR),
    .SYNC_STGS (SYNC_STGS)
  ) u_judge (
    .clk_i      (ref_clk_i),
    .rst_ni     (rst_ni),
    .ack_tgl_i  (ack_tgl),
    .hold_i     (hold_cnt),
    .cap_o      (cap_cnt),
    .cap_vld_o  (cap_vld),
    .verd_vld_o (verd_vld),
    .flag_o     (freq_err_o)
  );

endmodule

// File: rtl/fed_checker.sv
module fed_checker #(
  parameter int unsigned GATE_LEN = 1600,
  parameter int unsigned CNT_W    = 13,
  parameter int unsigned SET_THR  = 24,
  parameter int unsigned CLR_THR  = 8
) (
  input logic             ref_clk_i,
  input logic             rec_clk_i,
  input logic             rst_ni,
  input logic             freq_err_o,
  input logic [CNT_W-1:0] rec_cnt,
  input logic [CNT_W-1:0] hold_cnt,
  input logic             gate_edge,
  input logic [CNT_W-1:0] cap_cnt,
  input logic             cap_vld,
  input logic             verd_vld
);

  logic [31:0] c32;
  logic        too_far, close_in, seen_q;

  assign c32      = 32'(cap_cnt);
  assign too_far  = (c32 > GATE_LEN + SET_THR) || (c32 + SET_THR < GATE_LEN);
  assign close_in = (c32 + CLR_THR > GATE_LEN) && (c32 < GATE_LEN + CLR_THR);

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_q <= 1'b0;
    else if (verd_vld) seen_q <= 1'b1;
  end

  AST_FLAG_AFTER_RESET: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !seen_q |-> freq_err_o); // R1
  AST_SET_ON_GAP: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    cap_vld && too_far |=> ##1 freq_err_o); // R3
  AST_CLR_ON_MATCH: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    cap_vld && close_in |=> ##1 !freq_err_o); // R4
  AST_HOLD_IN_BAND: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    cap_vld && !too_far && !close_in |=> ##1 $stable(freq_err_o)); // R5
  AST_CHANGE_AFTER_VERDICT: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !$stable(freq_err_o) |-> $past(verd_vld)); // R6
  AST_SINGLE_CAPTURE: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    cap_vld |=> !cap_vld); // R6
  AST_HOLD_STABLE: assert property (@(posedge rec_clk_i) disable iff (!rst_ni)
    !gate_edge |=> $stable(hold_cnt)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge rec_clk_i) disable iff (!rst_ni)
    (&rec_cnt) && !gate_edge |=> (&rec_cnt)); // R8

endmodule

bind freq_err_det fed_checker #(
  .GATE_LEN (GATE_LEN),
  .CNT_W    (CNT_W),
  .SET_THR  (SET_THR),
  .CLR_THR  (CLR_THR)
) u_chk (
  .ref_clk_i  (ref_clk_i),
  .rec_clk_i  (rec_clk_i),
  .rst_ni     (rst_ni),
  .freq_err_o (freq_err_o),
  .rec_cnt    (rec_cnt),
  .hold_cnt   (hold_cnt),
  .gate_edge  (gate_edge_rec),
  .cap_cnt    (cap_cnt),
  .cap_vld    (cap_vld),
  .verd_vld   (verd_vld)
);

// File: tb/freq_err_det_tb_top.sv
`timescale 1ps/1ps
module freq_err_det_tb_top;

  localparam int REF_PERIOD_PS = 80000;
  localparam int GATE          = 400;
  localparam int SET_T         = GATE * 3 / 200;
  localparam int CLR_T         = GATE / 200;
  localparam int CMAX          = (1 << ($clog2(GATE) + 2)) - 1;

  logic ref_clk = 1'b0;
  logic rec_clk = 1'b0;
  logic rst_ni  = 1'b0;
  logic freq_err_o;
  int   rec_half = 5000;

  int total = 0, bad = 0;
  bit done = 0;
  int since = 0, changes = 0, viol = 0;
  logic last_flag = 1'b1;
  logic exp_flag = 1'b1;
  int cur_tr = 10000;

  freq_err_det #(.GATE_LEN(GATE)) dut_i (
    .ref_clk_i  (ref_clk),
    .rec_clk_i  (rec_clk),
    .rst_ni     (rst_ni),
    .freq_err_o (freq_err_o)
  );

  always #(REF_PERIOD_PS / 2) ref_clk = ~ref_clk;

  initial begin
    void'($urandom(32'd4177));
    #($urandom % 9000);
    forever #(rec_half) rec_clk = ~rec_clk;
  end

  // R6: spacing between flag changes, sampled away from the active edge
  always @(negedge ref_clk) begin
    if (!rst_ni) begin
      since = 0;
      last_flag = freq_err_o;
    end else begin
      if (freq_err_o !== last_flag) begin
        if (changes > 0 && since < GATE) viol++;
        changes++;
        since = 0;
      end else begin
        since++;
      end
      last_flag = freq_err_o;
    end
  end

  function automatic int model_count(int tr_ps);
    int c;
    c = (GATE * REF_PERIOD_PS + 4 * tr_ps) / (8 * tr_ps);
    return (c > CMAX) ? CMAX : c;
  endfunction

  function automatic logic model_flag(logic prev, int tr_ps);
    int g;
    g = model_count(tr_ps) - GATE;
    if (g < 0) g = -g;
    if (g > SET_T) return 1'b1;
    if (g < CLR_T) return 1'b0;
    return prev;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: freq_err_o=%0b expected=%0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic wait_win(int n);
    repeat (n * GATE + 40) @(negedge ref_clk);
  endtask

  task automatic apply(int tr_ps, string tag);
    rec_half = tr_ps / 2;
    cur_tr = tr_ps;
    exp_flag = model_flag(exp_flag, tr_ps);
    wait_win(3);
    chk(tag, freq_err_o, exp_flag);
  endtask

  initial begin
    repeat (60000) @(posedge ref_clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge ref_clk);
    chk("R1 flag during reset", freq_err_o, 1'b1);
    rst_ni = 1'b1;
    repeat (300) @(negedge ref_clk);
    chk("R1 flag before first window", freq_err_o, 1'b1);
    wait_win(1);
    exp_flag = 1'b0;
    chk("R2 nominal x8 clears", freq_err_o, 1'b0);

    apply(9500,  "R3 fast sets");
    apply(9900,  "R5 hold high");
    apply(10000, "R4 match clears");
    apply(9900,  "R5 hold low");
    apply(10600, "R3 slow sets");
    apply(10000, "R4 match clears again");
    apply(1634,  "R8 saturation no wrap");
    apply(10000, "R4 recover after saturation");

    // R7: random band walk; hold targets stay on the side of the current rate
    for (int i = 0; i < 8; i++) begin
      int pick, tr;
      pick = $urandom % 6;
      case (pick)
        0: tr = 9500;
        1: tr = 10600;
        2: tr = 10800;
        3: tr = 10000;
        4: tr = 9990;
        default: tr = (cur_tr > 10000) ? 10100 : 9900;
      endcase
      apply(tr, "R7 random phase walk");
    end

    chk("R6 change spacing", (viol == 0 && changes >= 6), 1'b1);

    @(negedge ref_clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge ref_clk);
    chk("R1 flag on mid-run reset", freq_err_o, 1'b1);
    rec_half = 5000;
    rst_ni = 1'b1;
    repeat (300) @(negedge ref_clk);
    chk("R1 held after mid-run reset", freq_err_o, 1'b1);
    wait_win(1);
    chk("R2 clears after mid-run reset", freq_err_o, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule